// File: doc/BRIEF.md
# Compare-Match Toggle Timer

This block is an 8-bit up-counter paired with a compare register. While the run control is set, the counter advances once for each count tick. When the count equals the compare value on a tick, the counter returns to zero and a one-cycle match interrupt is raised. The same event can invert an output flip-flop. That flip-flop drives the timer pin, so a fixed compare value yields a square wave with a 50% duty cycle.

Software sets the compare value through one write port and the control bits through another. The control bits are run, invert-on-match, pin enable, and two strobes that force the output flip-flop high or low. The count tick is a one-cycle enable that stands in for a divided count clock. No data stream passes through this block, so every pin is a plain control or status signal and no valid/ready handshake or back-pressure applies.

Top module: `cm_toggle_timer`

## Requirements
- R1: After synchronous reset the pin and the match interrupt are low. The counter, the compare value, all control bits and the output flip-flop are zero.
- R2: While run is 0 the counter is held at zero and no match interrupt occurs. After run is written to 1, the first match comes (compare value + 1) ticks after counting starts, so every restart begins a full interval.
- R3: The counter advances only in cycles where the count tick is high. With ticks on every other cycle, the interval between matches doubles.
- R4: A match happens when the count equals the compare value on a tick. The counter then returns to zero, and the match interrupt is high for exactly the one cycle in which the counter holds zero after that event.
- R5: On a match, the output flip-flop inverts when invert-on-match is 1 and keeps its value when it is 0.
- R6: The pin equals the output flip-flop when pin enable is 1 and is low when it is 0. Clearing pin enable does not change the flip-flop.
- R7: A control write with set=1 and clr=0 forces the flip-flop to 1, and set=0 with clr=1 forces it to 0. Writing both as 1 or both as 0 leaves it unchanged. A force wins over an inversion at the same clock edge.
- R8: A compare value of 0x00 gives a match, and with inversion a pin toggle, on every tick.
- R9: A compare write takes effect at the next comparison with no buffering, including in the middle of an interval.
- R10: With a fixed compare value C and a tick every cycle, the pin toggles every C+1 cycles (a 50% duty square wave). This holds up to C = 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Count tick, one per count-clock period |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | Compare value to write |
| ctl_we | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run control value |
| ctl_inv_en | input | 1 | Invert-on-match enable value |
| ctl_out_en | input | 1 | Pin enable value |
| ctl_lvl_set | input | 1 | Force-high strobe, used with ctl_we |
| ctl_lvl_clr | input | 1 | Force-low strobe, used with ctl_we |
| tmr_out | output | 1 | Timer pin value |
| match_irq | output | 1 | One-cycle match interrupt |

## Verification
Continuous ticks are run with compare values 3, 0x00 and 0xFF. These show whether the interval is C+1, whether the zero case collapses to a match on every tick, and whether the full 8-bit range is reached without wrap errors. Ticks on alternate cycles separate counting on ticks from counting on clocks. A stop-and-restart sequence and a compare rewrite in mid-interval separate a counter held at zero from one that keeps its count, and a live compare from a buffered one. Writes with inversion off, with the pin disabled, and with all four strobe combinations (one of them at the same edge as a toggle) isolate each path into the output flip-flop.

// File: rtl/cm_timer_pkg.sv
`timescale 1ns/1ps
package cm_timer_pkg;
  typedef struct packed {
    logic run;
    logic inv_en;
    logic out_en;
  } cm_ctl_t;
endpackage

// File: rtl/cm_timer_regs.sv
`timescale 1ns/1ps
module cm_timer_regs
  import cm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             ctl_we,
  input  cm_ctl_t          ctl_wdata,
  output logic [CNT_W-1:0] cmp_q,
  output cm_ctl_t          ctl_q
);
  // Compare value is live: no shadow copy, used at the next comparison.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      ctl_q <= '0;
    end else begin
      if (cmp_we) cmp_q <= cmp_wdata;
      if (ctl_we) ctl_q <= ctl_wdata;
    end
  end
endmodule

// File: rtl/cm_timer_counter.sv
`timescale 1ns/1ps
module cm_timer_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp,
  output logic             hit,
  output logic             irq_q,
  output logic [CNT_W-1:0] cnt_q
);
  always_comb hit = run && tick && (cnt_q == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit;
      if (!run || hit) cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cm_timer_outff.sv
`timescale 1ns/1ps
module cm_timer_outff (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic inv_en,
  input  logic force_we,
  input  logic lvl_set,
  input  logic lvl_clr,
  input  logic out_en,
  output logic ff_q,
  output logic pin
);
  logic force_hi, force_lo;

  always_comb begin
    force_hi = force_we && lvl_set && !lvl_clr;
    force_lo = force_we && lvl_clr && !lvl_set;
  end

  // Software force has priority over a same-edge inversion.
  always_ff @(posedge clk) begin
    if (rst)                 ff_q <= 1'b0;
    else if (force_hi)       ff_q <= 1'b1;
    else if (force_lo)       ff_q <= 1'b0;
    else if (hit && inv_en)  ff_q <= ~ff_q;
  end

  always_comb pin = ff_q && out_en;
endmodule

// File: rtl/cm_toggle_timer.sv
`timescale 1ns/1ps
module cm_toggle_timer
  import cm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic             ctl_inv_en,
  input  logic             ctl_out_en,
  input  logic             ctl_lvl_set,
  input  logic             ctl_lvl_clr,
  output logic             tmr_out,
  output logic             match_irq
);
  cm_ctl_t          ctl_wdata, ctl_q;
  logic [CNT_W-1:0] cmp_q, cnt_q;
  logic             hit, ff_q;
  logic             run_q, inv_en_q, out_en_q;

  always_comb begin
    ctl_wdata.run    = ctl_run;
    ctl_wdata.inv_en = ctl_inv_en;
    ctl_wdata.out_en = ctl_out_en;
    run_q    = ctl_q.run;
    inv_en_q = ctl_q.inv_en;
    out_en_q = ctl_q.out_en;
  end

  cm_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cmp_q(cmp_q), .ctl_q(ctl_q)
  );

  cm_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .run(run_q), .tick(tick_en), .cmp(cmp_q),
    .hit(hit), .irq_q(match_irq), .cnt_q(cnt_q)
  );

  cm_timer_outff u_off (
    .clk(clk), .rst(rst),
    .hit(hit), .inv_en(inv_en_q),
    .force_we(ctl_we), .lvl_set(ctl_lvl_set), .lvl_clr(ctl_lvl_clr),
    .out_en(out_en_q),
    .ff_q(ff_q), .pin(tmr_out)
  );
endmodule

// File: rtl/cm_toggle_timer_chk.sv
`timescale 1ns/1ps
module cm_toggle_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             ctl_we,
  input logic             ctl_lvl_set,
  input logic             ctl_lvl_clr,
  input logic             tmr_out,
  input logic             match_irq,
  input logic             run_q,
  input logic             inv_en_q,
  input logic             out_en_q,
  input logic             ff_q,
  input logic [CNT_W-1:0] cnt_q
);
  // R2
  stopped_holds_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (cnt_q == '0));
  // R2
  stopped_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !match_irq);
  // R3
  no_tick_no_count_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !tick_en) |=> $stable(cnt_q));
  // R4
  irq_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    match_irq |-> ($past(tick_en) && cnt_q == '0));
  // R5
  no_inv_holds_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (!inv_en_q && !ctl_we) |=> $stable(ff_q));
  // R6
  pin_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !out_en_q |-> !tmr_out);
  // R7
  force_high_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_lvl_set && !ctl_lvl_clr) |=> ff_q);
  // R7
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_lvl_clr && !ctl_lvl_set) |=> !ff_q);
endmodule

bind cm_toggle_timer cm_toggle_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en),
  .ctl_we(ctl_we), .ctl_lvl_set(ctl_lvl_set), .ctl_lvl_clr(ctl_lvl_clr),
  .tmr_out(tmr_out), .match_irq(match_irq),
  .run_q(run_q), .inv_en_q(inv_en_q), .out_en_q(out_en_q),
  .ff_q(ff_q), .cnt_q(cnt_q)
);

// File: tb/cm_toggle_timer_tb.sv
`timescale 1ns/1ps
module cm_toggle_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       cmp_we = 1'b0;
  logic [7:0] cmp_wdata = '0;
  logic       ctl_we = 1'b0;
  logic       ctl_run = 1'b0, ctl_inv_en = 1'b0, ctl_out_en = 1'b0;
  logic       ctl_lvl_set = 1'b0, ctl_lvl_clr = 1'b0;
  logic       tmr_out, match_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cm_toggle_timer u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .ctl_we(ctl_we), .ctl_run(ctl_run), .ctl_inv_en(ctl_inv_en),
    .ctl_out_en(ctl_out_en), .ctl_lvl_set(ctl_lvl_set), .ctl_lvl_clr(ctl_lvl_clr),
    .tmr_out(tmr_out), .match_irq(match_irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cmp(input int v);
    cmp_wdata = v[7:0];
    cmp_we = 1'b1;
    step();
    cmp_we = 1'b0;
  endtask

  task automatic wr_ctl(input bit run, input bit inv, input bit oen,
                        input bit set, input bit clr);
    ctl_run = run; ctl_inv_en = inv; ctl_out_en = oen;
    ctl_lvl_set = set; ctl_lvl_clr = clr;
    ctl_we = 1'b1;
    step();
    ctl_we = 1'b0; ctl_lvl_set = 1'b0; ctl_lvl_clr = 1'b0;
  endtask

  // Steps n cycles, records match timing and compares the pin to a model.
  task automatic watch(input int n, input bit alt, input bit inv, input bit oen,
                       input bit ff0, output int nirq, output int first,
                       output int gap, output int bad);
    bit ff = ff0;
    int last = -1;
    nirq = 0; first = -1; gap = -1; bad = 0;
    for (int i = 1; i <= n; i++) begin
      tick_en = alt ? (i % 2 == 1) : 1'b1;
      step();
      if (match_irq) begin
        nirq++;
        if (first < 0) first = i;
        else if (gap < 0) gap = i - last;
        last = i;
        if (inv) ff = ~ff;
      end
      if (tmr_out !== (ff & oen)) bad++;
    end
    tick_en = 1'b1;
  endtask

  task automatic t_reset();
    check(tmr_out === 1'b0, "R1", "pin after reset", int'(tmr_out), 0);
    check(match_irq === 1'b0, "R1", "irq after reset", int'(match_irq), 0);
    // compare resets to zero: starting without a compare write matches every tick
    wr_ctl(1, 0, 0, 0, 0);
    step();
    check(match_irq === 1'b1, "R1", "reset compare of zero matches at once", int'(match_irq), 1);
    wr_ctl(0, 0, 0, 0, 1);
  endtask

  task automatic t_period(input int c, input string req);
    int nirq, first, gap, bad;
    wr_cmp(c);
    wr_ctl(0, 0, 1, 0, 1);
    wr_ctl(1, 1, 1, 0, 0);
    watch(3 * (c + 1), 1'b0, 1'b1, 1'b1, 1'b0, nirq, first, gap, bad);
    check(first == c + 1, req, "first match after start", first, c + 1);
    check(gap == c + 1, req, "interval between matches", gap, c + 1);
    check(nirq == 3, "R4", "one-cycle pulses counted", nirq, 3);
    check(bad == 0, "R10", "pin square wave mismatches", bad, 0);
    wr_ctl(0, 0, 0, 0, 1);
  endtask

  task automatic t_tick();
    int nirq, first, gap, bad;
    wr_cmp(2);
    wr_ctl(1, 1, 1, 0, 1);
    watch(30, 1'b1, 1'b1, 1'b1, 1'b0, nirq, first, gap, bad);
    check(gap == 6, "R3", "interval with alternate ticks", gap, 6);
    check(bad == 0, "R3", "pin mismatches with alternate ticks", bad, 0);
    wr_ctl(0, 0, 0, 0, 1);
  endtask

  task automatic t_noinv();
    int nirq, first, gap, bad;
    wr_cmp(1);
    wr_ctl(0, 0, 1, 1, 0);
    wr_ctl(1, 0, 1, 0, 0);
    watch(12, 1'b0, 1'b0, 1'b1, 1'b1, nirq, first, gap, bad);
    check(nirq == 6, "R4", "matches with inversion off", nirq, 6);
    check(bad == 0, "R5", "pin held high with inversion off", bad, 0);
    wr_ctl(0, 0, 0, 0, 1);
  endtask

  task automatic t_oen();
    int nirq, first, gap, bad;
    wr_cmp(1);
    wr_ctl(1, 1, 0, 0, 0);
    watch(10, 1'b0, 1'b1, 1'b0, 1'b0, nirq, first, gap, bad);
    check(bad == 0, "R6", "pin low while disabled", bad, 0);
    wr_ctl(0, 0, 1, 1, 0);
    check(tmr_out === 1'b1, "R6", "pin follows forced high", int'(tmr_out), 1);
    wr_ctl(0, 0, 0, 0, 0);
    check(tmr_out === 1'b0, "R6", "pin low after disable", int'(tmr_out), 0);
    wr_ctl(0, 0, 1, 0, 0);
    check(tmr_out === 1'b1, "R6", "flip-flop kept while disabled", int'(tmr_out), 1);
    wr_ctl(0, 0, 0, 0, 1);
  endtask

  task automatic t_level();
    wr_ctl(0, 0, 1, 1, 0);
    check(tmr_out === 1'b1, "R7", "set=1 clr=0 forces high", int'(tmr_out), 1);
    wr_ctl(0, 0, 1, 1, 1);
    check(tmr_out === 1'b1, "R7", "both strobes leave high", int'(tmr_out), 1);
    wr_ctl(0, 0, 1, 0, 1);
    check(tmr_out === 1'b0, "R7", "set=0 clr=1 forces low", int'(tmr_out), 0);
    wr_ctl(0, 0, 1, 1, 1);
    check(tmr_out === 1'b0, "R7", "both strobes leave low", int'(tmr_out), 0);
    wr_ctl(0, 0, 1, 0, 0);
    check(tmr_out === 1'b0, "R7", "no strobes leave low", int'(tmr_out), 0);
    // force at the same edge as a toggle: compare 0, running, inversion on
    wr_cmp(0);
    wr_ctl(1, 1, 1, 0, 0);
    wr_ctl(1, 1, 1, 1, 0);
    check(tmr_out === 1'b1, "R7", "force wins over same-edge toggle", int'(tmr_out), 1);
    step();
    check(tmr_out === 1'b0, "R8", "compare zero toggles next tick", int'(tmr_out), 0);
    wr_ctl(0, 0, 0, 0, 1);
  endtask

  task automatic t_stop();
    int quiet = 0;
    int n = 0;
    wr_cmp(4);
    wr_ctl(1, 1, 1, 0, 1);
    for (int i = 0; i < 7; i++) step();
    wr_ctl(0, 1, 1, 0, 0);
    for (int i = 0; i < 20; i++) begin
      step();
      if (match_irq) quiet++;
    end
    check(quiet == 0, "R2", "no match while stopped", quiet, 0);
    wr_ctl(1, 1, 1, 0, 0);
    while (!match_irq && n < 50) begin
      step();
      n++;
    end
    check(n == 5, "R2", "restart gives full interval", n, 5);
    wr_ctl(0, 0, 0, 0, 1);
  endtask

  task automatic t_live_cmp();
    int n = 0;
    wr_cmp(5);
    wr_ctl(1, 0, 0, 0, 0);
    while (!match_irq && n < 50) begin
      step();
      n++;
    end
    check(n == 6, "R9", "interval before rewrite", n, 6);
    wr_cmp(9);
    n = 1;
    while (!match_irq && n < 50) begin
      step();
      n++;
    end
    check(n == 10, "R9", "new compare used mid-interval", n, 10);
    wr_ctl(0, 0, 0, 0, 1);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_period(3, "R10");
    t_period(0, "R8");
    t_period(255, "R10");
    t_tick();
    t_noinv();
    t_oen();
    t_level();
    t_stop();
    t_live_cmp();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule